// File: doc/BRIEF.md
# Runahead Mode Controller

This block moves a simple in-order scalar core between normal execution and runahead execution. When a cache miss is reported, the core does not stall. The controller takes a checkpoint of the whole architectural register file into a backup bank, records the PC of the stalled instruction, and sends fetch to a new address. That address depends on which cache missed. For an instruction-cache miss, fetch goes to the start of the next sequential line. For a data-cache miss, fetch goes to the instruction that follows the stalled one.

While runahead lasts, the pipeline keeps writing results into the working register file. Each write carries an invalid flag, so a result that depends on missing data is tagged as invalid. None of this work is architectural. When the miss is serviced, a one-cycle pulse moves the controller into a single restore cycle. In that cycle every register is reloaded from the backup bank in parallel and every invalid flag is cleared. The controller also sends a one-cycle pulse to the data cache, which clears that cache's own runahead-invalid word flags. Fetch is then sent back to the saved PC.

The controller owns the register file and gives it a configurable number of combinational read ports. The pipeline, the caches and any prefetching are outside this block.

Top module: `runahead_ctrl`

## Requirements
- R1: After a synchronous reset, the controller is in normal mode. `ahead_active`, `redirect_valid` and `inv_clear` are 0, and every register reads as zero with its invalid flag at 0 (0 = valid).
- R2: In normal mode, a write (`wr_en`=1) stores `wr_data` at `wr_addr` on the next clock edge, and `wr_inv` is ignored: the register still reads with invalid flag 0. The read ports are combinational on `rd_addr`.
- R3: A `miss_valid` pulse in normal mode sets `ahead_active` to 1 from the next cycle onward. The backup bank takes every register, and a write in that same cycle is included in the backup.
- R4: One cycle after entry, `redirect_valid` is 1 for exactly one cycle. If `miss_ifetch`=1 (instruction-cache miss), `redirect_pc` is `miss_pc` rounded down to a `LINE_BYTES` boundary plus `LINE_BYTES`. If `miss_ifetch`=0 (data-cache miss), `redirect_pc` is `miss_pc` + `INSN_BYTES`.
- R5: In runahead mode, a write stores `wr_data` and sets that register's invalid flag to `wr_inv` (1 = invalid).
- R6: A `miss_valid` pulse while in runahead or restore is ignored. The saved PC and the backup bank keep their values, and no redirect is issued.
- R7: A `miss_done` pulse in runahead mode starts a restore cycle, during which `ahead_active` is 0. A `miss_done` pulse in normal mode has no effect.
- R8: At the end of the restore cycle, every register holds its checkpointed value and every invalid flag is 0. `inv_clear` and `redirect_valid` are 1 for one cycle, with `redirect_pc` equal to the saved initiating PC. A write presented during the restore cycle is dropped.
- R9: After the return to normal mode, a further miss starts a new episode with a fresh checkpoint and a newly saved PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | One-cycle pulse reporting a cache miss |
| miss_ifetch | input | 1 | 1 = instruction-cache miss, 0 = data-cache miss |
| miss_pc | input | PCW | PC of the instruction that missed |
| miss_done | input | 1 | One-cycle pulse when the miss has been serviced |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | RAW | Register write index |
| wr_data | input | DW | Register write data |
| wr_inv | input | 1 | Invalid flag of the written result |
| rd_addr | input | NRD*RAW | Read indices, port k in bits [k*RAW +: RAW] |
| rd_data | output | NRD*DW | Read data, port k in bits [k*DW +: DW] |
| rd_inv | output | NRD | Invalid flag per read port |
| ahead_active | output | 1 | 1 while in runahead mode |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | PCW | Fetch redirect target |
| inv_clear | output | 1 | One-cycle pulse telling the data cache to clear its runahead-invalid flags |

## Verification
The main function is exercised with three kinds of pattern. The first is a directed episode in which a write lands in the same cycle as the miss, which shows whether that write reaches the backup bank. The second is a series of instruction-cache and data-cache misses at unaligned PCs, which tells the two redirect targets apart. The third is a long random mix of writes with random invalid flags, misses that arrive during runahead or restore, and service pulses that arrive in normal mode; this separates ignored events from real mode changes. A behavioural model compares the mode flag, the redirect, the clear pulse and both read ports on every cycle, so a missed restore or a stale flag shows up in the cycle where it first differs.

// File: rtl/rah_pkg.sv
package rah_pkg;
  typedef enum logic [1:0] {
    RA_NORMAL  = 2'd0,
    RA_AHEAD   = 2'd1,
    RA_RESTORE = 2'd2
  } ra_mode_e;
endpackage

// File: rtl/rah_mode_fsm.sv
module rah_mode_fsm
  import rah_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic miss_valid,
  input  logic miss_done,
  output logic take_ckpt,
  output logic restore_now,
  output logic in_ahead,
  output logic ahead_active,
  output logic inv_clear
);
  ra_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      RA_NORMAL:  if (miss_valid) mode_d = RA_AHEAD;
      RA_AHEAD:   if (miss_done)  mode_d = RA_RESTORE;
      RA_RESTORE: mode_d = RA_NORMAL;
      default:    mode_d = RA_NORMAL;
    endcase
  end

  assign take_ckpt   = (mode_q == RA_NORMAL) && miss_valid;
  assign restore_now = (mode_q == RA_RESTORE);
  assign in_ahead    = (mode_q == RA_AHEAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= RA_NORMAL;
      ahead_active <= 1'b0;
      inv_clear    <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      ahead_active <= (mode_d == RA_AHEAD);
      inv_clear    <= restore_now;
    end
  end

  // R7
  restore_from_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == RA_RESTORE) |-> ($past(mode_q) == RA_AHEAD));

  // R8
  restore_single_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == RA_RESTORE) |=> (mode_q == RA_NORMAL));
endmodule

// File: rtl/rah_regbank.sv
module rah_regbank #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  parameter int NRD   = 2,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_ckpt,
  input  logic             restore_now,
  input  logic             in_ahead,
  input  logic             wr_en,
  input  logic [RAW-1:0]   wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_inv,
  input  logic [NRD*RAW-1:0] rd_addr,
  output logic [NRD*DW-1:0]  rd_data,
  output logic [NRD-1:0]     rd_inv
);
  logic [DW-1:0] work_q [NREGS];
  logic [DW-1:0] back_q [NREGS];
  logic [NREGS-1:0] bad_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == RAW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        work_q[i] <= '0;
        back_q[i] <= '0;
        bad_q[i]  <= 1'b0;
      end else begin
        if (restore_now) begin
          work_q[i] <= back_q[i];
          bad_q[i]  <= 1'b0;
        end else if (hit) begin
          work_q[i] <= wr_data;
          bad_q[i]  <= in_ahead & wr_inv;
        end
        if (take_ckpt)
          back_q[i] <= hit ? wr_data : work_q[i];
      end
    end

    // R6
    bk_hold_chk: assert property (@(posedge clk) disable iff (rst)
      in_ahead |=> $stable(back_q[i]));
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [RAW-1:0] a;
    assign a = rd_addr[k*RAW +: RAW];
    assign rd_data[k*DW +: DW] = work_q[a];
    assign rd_inv[k]           = bad_q[a];
  end

  // R2
  inv_only_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    (bad_q != '0) |-> (in_ahead || restore_now));
endmodule

// File: rtl/rah_pc_unit.sv
module rah_pc_unit #(
  parameter int PCW        = 32,
  parameter int LINE_BYTES = 32,
  parameter int INSN_BYTES = 4,
  localparam int LOFF      = $clog2(LINE_BYTES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take_ckpt,
  input  logic           restore_now,
  input  logic           in_ahead,
  input  logic           miss_ifetch,
  input  logic [PCW-1:0] miss_pc,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_pc
);
  logic [PCW-1:0] saved_q;
  logic [PCW-1:0] line_next, seq_next;

  assign line_next = {miss_pc[PCW-1:LOFF], {LOFF{1'b0}}} + PCW'(LINE_BYTES);
  assign seq_next  = miss_pc + PCW'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q        <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= 1'b0;
      if (take_ckpt) begin
        saved_q        <= miss_pc;
        redirect_valid <= 1'b1;
        redirect_pc    <= miss_ifetch ? line_next : seq_next;
      end else if (restore_now) begin
        redirect_valid <= 1'b1;
        redirect_pc    <= saved_q;
      end
    end
  end

  // R6
  saved_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_ahead |=> $stable(saved_q));

  // R8
  restore_target_chk: assert property (@(posedge clk) disable iff (rst)
    restore_now |=> (redirect_pc == saved_q));
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
  parameter int NREGS      = 16,
  parameter int DW         = 32,
  parameter int PCW        = 32,
  parameter int LINE_BYTES = 32,
  parameter int INSN_BYTES = 4,
  parameter int NRD        = 2,
  localparam int RAW       = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  input  logic               miss_ifetch,
  input  logic [PCW-1:0]     miss_pc,
  input  logic               miss_done,
  input  logic               wr_en,
  input  logic [RAW-1:0]     wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               wr_inv,
  input  logic [NRD*RAW-1:0] rd_addr,
  output logic [NRD*DW-1:0]  rd_data,
  output logic [NRD-1:0]     rd_inv,
  output logic               ahead_active,
  output logic               redirect_valid,
  output logic [PCW-1:0]     redirect_pc,
  output logic               inv_clear
);
  logic take_ckpt, restore_now, in_ahead;

  rah_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_done(miss_done),
    .take_ckpt(take_ckpt), .restore_now(restore_now), .in_ahead(in_ahead),
    .ahead_active(ahead_active), .inv_clear(inv_clear)
  );

  rah_regbank #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_bank (
    .clk(clk), .rst(rst), .take_ckpt(take_ckpt), .restore_now(restore_now),
    .in_ahead(in_ahead), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_inv(wr_inv), .rd_addr(rd_addr), .rd_data(rd_data), .rd_inv(rd_inv)
  );

  rah_pc_unit #(.PCW(PCW), .LINE_BYTES(LINE_BYTES), .INSN_BYTES(INSN_BYTES)) u_pc (
    .clk(clk), .rst(rst), .take_ckpt(take_ckpt), .restore_now(restore_now),
    .in_ahead(in_ahead), .miss_ifetch(miss_ifetch), .miss_pc(miss_pc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  // R4
  entry_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (ahead_active && !$past(ahead_active)) |-> redirect_valid);

  // R8
  clear_with_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    inv_clear |-> (redirect_valid && !ahead_active));

  // R8
  clear_all_valid_chk: assert property (@(posedge clk) disable iff (rst)
    inv_clear |-> (rd_inv == '0));
endmodule

// File: tb/runahead_ctrl_tb.sv
module runahead_ctrl_tb;
  localparam int NREGS = 16, DW = 32, PCW = 32, LINE = 32, INSN = 4, NRD = 2;
  localparam int RAW = $clog2(NREGS);

  logic clk = 0, rst = 1;
  logic miss_valid = 0, miss_ifetch = 0, miss_done = 0;
  logic [PCW-1:0] miss_pc = '0;
  logic wr_en = 0, wr_inv = 0;
  logic [RAW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NRD*RAW-1:0] rd_addr = '0;
  logic [NRD*DW-1:0] rd_data;
  logic [NRD-1:0] rd_inv;
  logic ahead_active, redirect_valid, inv_clear;
  logic [PCW-1:0] redirect_pc;

  int checks = 0, errors = 0, episodes = 0;
  bit done = 0;

  always #4 clk = ~clk;

  runahead_ctrl #(.NREGS(NREGS), .DW(DW), .PCW(PCW), .LINE_BYTES(LINE),
                  .INSN_BYTES(INSN), .NRD(NRD)) u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ifetch(miss_ifetch),
    .miss_pc(miss_pc), .miss_done(miss_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_inv(wr_inv), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_inv(rd_inv), .ahead_active(ahead_active), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .inv_clear(inv_clear)
  );

  // behavioural reference
  int m_mode = 0;  // 0 normal, 1 runahead, 2 restore
  logic [DW-1:0] m_rf [NREGS];
  logic [DW-1:0] m_bk [NREGS];
  bit m_inv [NREGS];
  logic [PCW-1:0] m_saved = '0, m_rpc = '0;
  bit m_rv = 0, m_clr = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_rv = 0; m_clr = 0; m_saved = '0;
      for (int i = 0; i < NREGS; i++) begin m_rf[i] = '0; m_bk[i] = '0; m_inv[i] = 0; end
    end else begin
      m_rv = 0; m_clr = 0;
      if (m_mode == 0) begin
        if (wr_en) begin m_rf[wr_addr] = wr_data; m_inv[wr_addr] = 0; end
        if (miss_valid) begin
          for (int i = 0; i < NREGS; i++) m_bk[i] = m_rf[i];
          m_saved = miss_pc; m_rv = 1;
          m_rpc = miss_ifetch ? ((miss_pc / LINE) * LINE + LINE) : (miss_pc + INSN);
          m_mode = 1; episodes++;
        end
      end else if (m_mode == 1) begin
        if (wr_en) begin m_rf[wr_addr] = wr_data; m_inv[wr_addr] = wr_inv; end
        if (miss_done) m_mode = 2;
      end else begin
        for (int i = 0; i < NREGS; i++) begin m_rf[i] = m_bk[i]; m_inv[i] = 0; end
        m_rv = 1; m_rpc = m_saved; m_clr = 1; m_mode = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      chk("R3 R7 R9 ahead_active", 64'(ahead_active), 64'(m_mode == 1));
      chk("R4 R6 R8 redirect_valid", 64'(redirect_valid), 64'(m_rv));
      if (m_rv) chk("R4 R6 R8 redirect_pc", 64'(redirect_pc), 64'(m_rpc));
      chk("R8 inv_clear", 64'(inv_clear), 64'(m_clr));
      for (int k = 0; k < NRD; k++) begin
        chk("R2 R5 R8 rd_data", 64'(rd_data[k*DW +: DW]), 64'(m_rf[rd_addr[k*RAW +: RAW]]));
        chk("R2 R5 R8 rd_inv", 64'(rd_inv[k]), 64'(m_inv[rd_addr[k*RAW +: RAW]]));
      end
    end
  end

  task automatic step();
    @(negedge clk);
    miss_valid = 0; miss_done = 0; wr_en = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state on all registers
    for (int k = 0; k < NREGS / 2; k++) begin
      rd_addr = {RAW'(2 * k + 1), RAW'(2 * k)};
      @(posedge clk); #2;
      chk("R1 reset data", 64'(rd_data), 64'(0));
      chk("R1 reset inv", 64'(rd_inv), 64'(0));
      chk("R1 reset mode", 64'({ahead_active, redirect_valid, inv_clear}), 64'(0));
    end
    // directed episode: same-cycle write during miss (R3), I-miss redirect (R4)
    step(); wr_en = 1; wr_addr = 3; wr_data = 32'h1111_0003; wr_inv = 1;
    step(); wr_en = 1; wr_addr = 5; wr_data = 32'hAAAA_0005;
    miss_valid = 1; miss_ifetch = 1; miss_pc = 32'h0000_1234;
    rd_addr = {RAW'(5), RAW'(3)};
    step(); wr_en = 1; wr_addr = 5; wr_data = 32'hDEAD_0005; wr_inv = 1;  // R5
    step(); miss_valid = 1; miss_pc = 32'h0000_9990;                        // R6
    step(); miss_done = 1;
    step(); wr_en = 1; wr_addr = 3; wr_data = 32'hBAD0_0003;                // dropped (R8)
    step(); step();
    // R9: data-cache miss episode
    miss_valid = 1; miss_ifetch = 0; miss_pc = 32'h0000_2006;
    step(); miss_done = 1;
    step(); miss_done = 1;  // arrives in restore/normal: ignored (R7)
    step(); step();
    // random mix
    for (int n = 0; n < 6000; n++) begin
      step();
      wr_en = ($urandom % 2) == 0;
      wr_addr = RAW'($urandom);
      wr_data = $urandom;
      wr_inv = $urandom % 2;
      miss_valid = ($urandom % 20) == 0;
      miss_ifetch = $urandom % 2;
      miss_pc = $urandom;
      miss_done = ($urandom % 12) == 0;
      rd_addr = NRD * RAW'($urandom);
      rd_addr = {RAW'($urandom), RAW'($urandom)};
    end
    step(); step();
    if (episodes < 10) begin
      errors++;
      $display("FAIL R9 too few episodes: actual %0d expected >= 10", episodes);
    end
    checks++;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule